// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register file of a load-store processor core. The program always sees sixteen 32-bit registers, numbered 0 to 15. Register 13 is the stack pointer, register 14 holds the return address, and register 15 is the program counter, which points at the next fetch. Behind the fixed logical numbering, the current processor mode decides which physical copy of some registers a number refers to. Each exception mode gets its own stack pointer and return-address register. The fast-interrupt mode also gets private copies of registers 8 to 12. System mode shares every register with user mode.

Two combinational read ports and one clocked write port all take 4-bit logical numbers, and all three are remapped through the 5-bit mode input. The program counter has its own register with an advance path from the fetch logic. A register write to number 15 overrides that advance. Writes take effect at the next rising clock edge, so a read in the same cycle as a write to the same register returns the old contents.

Top module: `banked_regfile`

## Requirements
- R1: With `rst_n` low at a rising edge, every physical register and the program counter become zero. After reset, every logical register reads zero in every mode.
- R2: Mode codes are 5'b10000 user, 5'b10001 fast interrupt, 5'b10010 interrupt, 5'b10011 supervisor, 5'b10111 abort, 5'b11011 undefined and 5'b11111 system. Any other code behaves exactly like user mode.
- R3: Logical registers 0 to 7 map to one shared physical register each, in every mode.
- R4: In fast-interrupt mode, logical registers 8 to 12 map to private copies. In all other modes they map to the user copies, so writes in one group never reach the other group.
- R5: Each of fast interrupt, interrupt, supervisor, abort and undefined has its own copy of registers 13 and 14. A write to 13 or 14 in one of these modes leaves the user-mode copies and the other modes' copies unchanged.
- R6: System mode reads and writes exactly the same physical registers as user mode.
- R7: A write with `wr_en` high updates its register at the next rising edge. A read of that register in the same cycle returns the previous value, and a read in the following cycle returns the new value.
- R8: Reading logical register 15 on either read port returns the current program counter, which is also driven on `pc_o`, in every mode.
- R9: When `pc_adv_en` is high and no write targets register 15, the program counter loads `pc_adv_val` at the next edge. When neither happens, it holds its value.
- R10: A write to logical register 15 loads `wr_data` into the program counter and takes priority over a simultaneous advance.
- R11: With `wr_en` low, no general register changes, whatever values `wr_addr` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 5 | Current processor mode code |
| rd_a_addr | input | 4 | Logical register number, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_addr | input | 4 | Logical register number, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Logical register number to write |
| wr_data | input | 32 | Write data |
| pc_adv_en | input | 1 | Load the program counter from the advance path |
| pc_adv_val | input | 32 | Next program-counter value from fetch |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions check the following on every cycle:
- the reset value of the program counter;
- write-then-read-back in an unchanged mode;
- the priority of a register-15 write over an advance;
- that the user copies of registers 13 and 14 hold while an exception mode writes its own copies;
- that every remapped index falls inside the physical array.

The bench's scenarios are needed for the properties that span mode changes:
- which group of modes shares registers 8 to 12, and which modes share 13 and 14;
- that unknown mode codes fall back to user;
- that system mode aliases user mode;
- that a disabled write leaves the registers untouched.

These properties hold only against a reference model that tracks every bank across many cycles.

// File: rtl/bank_pkg.sv
// Shared types and constants for the mode-banked register file.
// Assumes a 16-entry logical view with a 5-bit mode code.
package bank_pkg;

    localparam int LOG_AW   = 4;
    localparam int MODE_W   = 5;
    localparam int NUM_PHYS = 30;   // general registers, program counter excluded
    localparam int PIDX_W   = $clog2(NUM_PHYS);
    localparam int PC_NUM   = 15;
    localparam int SP_NUM   = 13;
    localparam int FIQ_LO   = 8;
    localparam int FIQ_BASE = 15;   // first private fast-interrupt slot for r8
    localparam int EXC_BASE = 20;   // first private r13/r14 pair

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    // Bank groups; order matters: the r13/r14 pair of bank k lives at EXC_BASE + 2*(k-1).
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_IRQ = 3'd2,
        BANK_SVC = 3'd3,
        BANK_ABT = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    // Turn a raw mode code into its register bank; system and unknown codes share user.
    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_FIQ;
            MODE_IRQ: return BANK_IRQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_UND: return BANK_UND;
            default:  return BANK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bank_map.sv
// Logical-to-physical register remapper.
// Purely combinational; one instance per register-file port.
// Assumes the physical layout:
//   0..14  user r0..r14
//   15..19 fast-interrupt r8..r12
//   20..29 r13/r14 pairs of the five exception banks
// Number 15 is flagged as the program counter rather than mapped.
module bank_map
    import bank_pkg::*;
(
    input  bank_e              bank,
    input  logic [LOG_AW-1:0]  log_addr,
    output logic [PIDX_W-1:0]  phys_idx,
    output logic               is_pc
);

    int unsigned idx;

    // Select the physical slot for the logical number under the given bank.
    always_comb begin
        idx   = 32'(log_addr);
        is_pc = 1'b0;
        if (int'(log_addr) == PC_NUM) begin
            is_pc = 1'b1;
            idx   = 0;
        end else if (int'(log_addr) >= SP_NUM) begin
            if (bank != BANK_USR)
                idx = EXC_BASE + 2 * (int'(bank) - 1) + (int'(log_addr) - SP_NUM);
        end else if (int'(log_addr) >= FIQ_LO) begin
            if (bank == BANK_FIQ)
                idx = FIQ_BASE + (int'(log_addr) - FIQ_LO);
        end
        phys_idx = PIDX_W'(idx);
    end

    // Remapped index must stay inside the physical array.
    always_comb begin
        p_idx_in_range_r3: assert (is_pc || int'(phys_idx) < NUM_PHYS)
            else $error("bank_map: index out of range");
    end

endmodule

// File: rtl/bank_storage.sv
// Physical register array: one write port, two combinational read ports.
// Assumes indices are pre-validated by bank_map; out-of-range reads return zero.
module bank_storage #(
    parameter int DATA_W   = 32,
    parameter int NUM_PHYS = 30,
    parameter int PIDX_W   = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PIDX_W-1:0] w_idx,
    input  logic [DATA_W-1:0] w_data,
    input  logic [PIDX_W-1:0] ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [PIDX_W-1:0] rb_idx,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] mem_q [NUM_PHYS];

    // Clear every slot on reset, otherwise update the one addressed slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_PHYS; i++) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (we && int'(w_idx) == i)
                mem_q[i] <= w_data;
        end
    end

    // Read port A, old contents during a same-cycle write.
    always_comb begin
        ra_data = '0;
        if (int'(ra_idx) < NUM_PHYS)
            ra_data = mem_q[ra_idx];
    end

    // Read port B, same rules as port A.
    always_comb begin
        rb_data = '0;
        if (int'(rb_idx) < NUM_PHYS)
            rb_data = mem_q[rb_idx];
    end

endmodule

// File: rtl/pc_reg.sv
// Program-counter register with two load sources.
// An architectural write (register 15) wins over the fetch advance path.
// Assumes both sources are already qualified by the caller.
module pc_reg #(
    parameter int               DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              adv_en,
    input  logic [DATA_W-1:0] adv_val,
    output logic [DATA_W-1:0] pc_q
);

    // Load the program counter, write before advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC;
        else if (wr_en)
            pc_q <= wr_val;
        else if (adv_en)
            pc_q <= adv_val;
    end

endmodule

// File: rtl/banked_regfile.sv
// Top of the mode-banked register file.
// Decodes the mode once, remaps the three port addresses, and steers
// register 15 to the program counter instead of the general array.
// Assumes a single write port and synchronous active-low reset.
module banked_regfile
    import bank_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] RESET_PC = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode,
    input  logic [LOG_AW-1:0]    rd_a_addr,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [LOG_AW-1:0]    rd_b_addr,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 wr_en,
    input  logic [LOG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 pc_adv_en,
    input  logic [DATA_W-1:0]    pc_adv_val,
    output logic [DATA_W-1:0]    pc_o
);

    localparam int NUM_PORTS = 3;   // read A, read B, write
    localparam int P_RA = 0;
    localparam int P_RB = 1;
    localparam int P_WR = 2;

    bank_e             cur_bank;
    logic [LOG_AW-1:0] port_addr [NUM_PORTS];
    logic [PIDX_W-1:0] port_idx  [NUM_PORTS];
    logic              port_pc   [NUM_PORTS];
    logic [DATA_W-1:0] arr_a, arr_b, pc_q;

    // Decode the processor mode into its bank group.
    always_comb cur_bank = mode_to_bank(mode);

    // Collect the port addresses for the remappers.
    always_comb begin
        port_addr[P_RA] = rd_a_addr;
        port_addr[P_RB] = rd_b_addr;
        port_addr[P_WR] = wr_addr;
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_map
        bank_map u_map (
            .bank     (cur_bank),
            .log_addr (port_addr[g]),
            .phys_idx (port_idx[g]),
            .is_pc    (port_pc[g])
        );
    end

    bank_storage #(
        .DATA_W   (DATA_W),
        .NUM_PHYS (NUM_PHYS),
        .PIDX_W   (PIDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && !port_pc[P_WR]),
        .w_idx   (port_idx[P_WR]),
        .w_data  (wr_data),
        .ra_idx  (port_idx[P_RA]),
        .ra_data (arr_a),
        .rb_idx  (port_idx[P_RB]),
        .rb_data (arr_b)
    );

    pc_reg #(
        .DATA_W   (DATA_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && port_pc[P_WR]),
        .wr_val  (wr_data),
        .adv_en  (pc_adv_en),
        .adv_val (pc_adv_val),
        .pc_q    (pc_q)
    );

    // Steer register 15 reads to the program counter.
    always_comb begin
        rd_a_data = port_pc[P_RA] ? pc_q : arr_a;
        rd_b_data = port_pc[P_RB] ? pc_q : arr_b;
        pc_o      = pc_q;
    end

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> pc_o == RESET_PC);

    p_user_sp_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank != BANK_USR && wr_en && wr_addr == 4'd13)
            |=> $stable(u_store.mem_q[13]));

    p_user_lr_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_bank != BANK_USR && wr_en && wr_addr == 4'd14)
            |=> $stable(u_store.mem_q[14]));

    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 4'd15)
            |=> (!(rd_a_addr == $past(wr_addr) && mode == $past(mode))
                 || rd_a_data == $past(wr_data)));

    p_pc_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_adv_en && !(wr_en && wr_addr == 4'd15)) |=> pc_o == $past(pc_adv_val));

    p_pc_write_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd15) |=> pc_o == $past(wr_data));

endmodule

// File: tb/banked_regfile_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic
// against a bank-indexed reference model.
module banked_regfile_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_adv_val = '0, pc_o;
    logic        wr_en = 1'b0, pc_adv_en = 1'b0;

    int checks = 0;
    int fails  = 0;

    // model[bank][logical]; bank 0 user/system, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
    logic [31:0] model [6][16];
    logic [31:0] mpc;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .rd_a_addr  (rd_a_addr),
        .rd_a_data  (rd_a_data),
        .rd_b_addr  (rd_b_addr),
        .rd_b_data  (rd_b_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .pc_adv_en  (pc_adv_en),
        .pc_adv_val (pc_adv_val),
        .pc_o       (pc_o)
    );

    function automatic int mode_bank(input logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic int eff_bank(input logic [4:0] m, input logic [3:0] a);
        int b = mode_bank(m);
        if (a < 8)  return 0;
        if (a < 13) return (b == 1) ? 1 : 0;
        return b;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] m, input logic [3:0] a);
        if (a == 4'd15) return mpc;
        return model[eff_bank(m, a)][a];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check reads before the edge, update model after it.
    task automatic step(input string tag, input logic [4:0] m,
                        input logic [3:0] ra, input logic [3:0] rb,
                        input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic pe, input logic [31:0] pv);
        @(negedge clk);
        mode = m; rd_a_addr = ra; rd_b_addr = rb;
        wr_en = we; wr_addr = wa; wr_data = wd;
        pc_adv_en = pe; pc_adv_val = pv;
        #1;
        check({tag, " port A"}, rd_a_data, exp_read(m, ra));
        check({tag, " port B"}, rd_b_data, exp_read(m, rb));
        check({tag, " pc"},     pc_o,      mpc);
        @(posedge clk);
        if (we && wa == 4'd15)  mpc = wd;
        else if (pe)            mpc = pv;
        if (we && wa != 4'd15)  model[eff_bank(m, wa)][wa] = wd;
    endtask

    task automatic rd(input string tag, input logic [4:0] m, input logic [3:0] ra, input logic [3:0] rb);
        step(tag, m, ra, rb, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic wr(input string tag, input logic [4:0] m, input logic [3:0] wa, input logic [31:0] wd);
        step(tag, m, wa, wa, 1'b1, wa, wd, 1'b0, 32'h0);
    endtask

    logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                              5'b10111, 5'b11011, 5'b11111, 5'b00101};

    initial begin
        repeat (CLK_PERIOD * 30000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 6; b++)
            for (int r = 0; r < 16; r++) model[b][r] = '0;
        mpc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything reads zero after reset, in every mode
        for (int k = 0; k < 8; k++)
            for (int r = 0; r < 16; r += 2) rd("R1 reset", modes[k], 4'(r), 4'(r + 1));

        // R7: same-cycle read sees old data, next cycle sees new
        wr("R7 same-cycle old", 5'b10000, 4'd3, 32'hA5A5_0003);
        rd("R7 next-cycle new", 5'b10000, 4'd3, 4'd3);

        // R3: low registers shared across modes
        wr("R3 write svc r5", 5'b10011, 4'd5, 32'h0000_5555);
        rd("R3 read fiq r5", 5'b10001, 4'd5, 4'd5);
        rd("R3 read usr r5", 5'b10000, 4'd5, 4'd3);

        // R4: fast-interrupt r8..r12 private
        wr("R4 write fiq r8", 5'b10001, 4'd8, 32'hF1F1_0008);
        wr("R4 write usr r12", 5'b10000, 4'd12, 32'h1111_000C);
        rd("R4 read usr r8", 5'b10000, 4'd8, 4'd12);
        rd("R4 read irq r8", 5'b10010, 4'd8, 4'd12);
        rd("R4 read fiq r8", 5'b10001, 4'd8, 4'd12);

        // R5: exception r13/r14 banked
        wr("R5 write irq r13", 5'b10010, 4'd13, 32'h1230_000D);
        wr("R5 write svc r14", 5'b10011, 4'd14, 32'h5C0_000E);
        rd("R5 read usr r13/r14", 5'b10000, 4'd13, 4'd14);
        rd("R5 read irq r13/r14", 5'b10010, 4'd13, 4'd14);
        rd("R5 read abt r13/r14", 5'b10111, 4'd13, 4'd14);
        rd("R5 read svc r13/r14", 5'b10011, 4'd13, 4'd14);

        // R6: system aliases user
        wr("R6 write sys r14", 5'b11111, 4'd14, 32'h5757_000E);
        rd("R6 read usr r14", 5'b10000, 4'd14, 4'd13);

        // R2: unknown mode behaves as user
        wr("R2 write bad-mode r13", 5'b00000, 4'd13, 32'hBAD0_000D);
        rd("R2 read usr r13", 5'b10000, 4'd13, 4'd8);

        // R11: disabled write ignored
        step("R11 disabled write", 5'b10000, 4'd3, 4'd3, 1'b0, 4'd3, 32'hDEAD_BEEF, 1'b0, 32'h0);
        rd("R11 readback r3", 5'b10000, 4'd3, 4'd3);

        // R9 / R10 / R8: program counter paths
        step("R9 advance", 5'b10000, 4'd15, 4'd0, 1'b0, 4'd0, 32'h0, 1'b1, 32'h0000_0104);
        rd("R8 pc via read ports", 5'b10010, 4'd15, 4'd15);
        step("R10 write beats advance", 5'b10011, 4'd15, 4'd15, 1'b1, 4'd15, 32'h0000_8000, 1'b1, 32'h0000_0108);
        rd("R10 pc after write", 5'b10001, 4'd15, 4'd15);

        // R7 random traffic across all modes and ports
        for (int n = 0; n < N_RANDOM; n++) begin
            step("R7 random", modes[$urandom_range(7)],
                 4'($urandom_range(15)), 4'($urandom_range(15)),
                 1'($urandom_range(1)), 4'($urandom_range(15)), $urandom(),
                 1'($urandom_range(1)), $urandom());
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule